// File: doc/BRIEF.md
# Banked Edge Interrupt Controller

This block watches a set of external input lines grouped into banks of 32. Each line can be armed to detect rising edges, falling edges, both, or neither. A detected edge latches a bit in one of two pending registers, one for rising edges and one for falling edges. Software clears pending bits by writing ones to them. Each bank drives a level-high interrupt while any unmasked line has a pending bit. A combined interrupt output covers all banks. Lines that are enabled for events also give a one-cycle event pulse when an armed edge is detected.

Software reaches the registers through a plain strobe interface: a bank selector, a register selector, a write strobe with a data word, and a read strobe. Read data is returned one cycle after the read strobe. Every input line passes through a two-flop synchronizer before edge detection, so the inputs may be asynchronous to the clock.

Top module: `edge_irq_hub`

## Requirements
- R1: Line n belongs to bank n/32 and sits at bit n%32 of every register of that bank. An edge on a line touches no other bank.
- R2: A rising edge on a line whose rise-select bit is 1 sets that line's bit in the rise-pending register. An edge on a line with both select bits 0 latches nothing.
- R3: A falling edge on a line whose fall-select bit is 1 sets that line's bit in the separate fall-pending register. A line with both select bits set latches each edge into the matching register.
- R4: A write to either pending register clears exactly the bits where the written word is 1 and leaves all other bits unchanged. Without such a write, a pending bit stays set.
- R5: A bank's interrupt output is high while any line has (rise-pending OR fall-pending) AND interrupt-mask equal to 1. A mask bit of 1 enables the line. A pending bit latches even while its line is masked. The combined output is the OR of all bank outputs. Both outputs follow pending and mask with one register stage.
- R6: A line whose interrupt-mask bit and event-mask bit are both 1 gives a one-cycle pulse on its event output bit when an armed edge is detected. A line with the interrupt mask at 0 gives no pulse.
- R7: If an edge is detected in the same cycle as a write that clears that pending bit, the bit stays set.
- R8: Reset (synchronous, active high) clears all select, mask and pending registers. The interrupt, combined and event outputs are then low.
- R9: The register selector encoding is 0 rise-select, 1 fall-select, 2 interrupt-mask, 3 event-mask, 4 rise-pending, 5 fall-pending. Read data appears one cycle after the read strobe. A bank selector beyond the last bank reads as zero.
- R10: An input change is registered by the two-flop synchronizer. The event pulse for that change appears on the third clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_i | input | NUM_BANKS*BANK_W | External input lines, possibly asynchronous |
| bank_sel | input | BSEL_W | Bank addressed by the register access |
| reg_sel | input | 3 | Register addressed within the bank (R9 encoding) |
| wr_en | input | 1 | Write strobe |
| wdata | input | BANK_W | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | BANK_W | Read data, registered |
| bank_irq_o | output | NUM_BANKS | Level-high interrupt per bank |
| any_irq_o | output | 1 | OR of all bank interrupts |
| evt_o | output | NUM_BANKS*BANK_W | One-cycle event pulse per line |

## Verification
The hardest case to reach is the collision in R7. A clear-write must land in exactly the cycle in which the synchronized edge is detected. The bench first sets the pending bit. It then drops the line, raises it again, and counts two falling clock edges through the synchronizer before it asserts the clear strobe. The clear and the edge detection therefore meet at the same rising edge. A readback then shows whether the bit survived. The event pulse timing in R10 is reached the same way, by counting edges from the input change and checking the cycle before the pulse, the pulse cycle and the cycle after it.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int LINES_PER_BANK = 32;
  localparam int REG_SEL_W      = 3;

  typedef enum logic [REG_SEL_W-1:0] {
    REG_RISE_SEL  = 3'd0,
    REG_FALL_SEL  = 3'd1,
    REG_IRQ_MASK  = 3'd2,
    REG_EVT_MASK  = 3'd3,
    REG_RISE_PEND = 3'd4,
    REG_FALL_PEND = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/line_sync.sv
// Two-flop synchronizer followed by a previous-sample stage for edge detection.
module line_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/edge_bank.sv
// One bank: trigger selects, masks, two pending registers, irq and event outputs.
module edge_bank
  import edge_irq_pkg::*;
#(
  parameter int W = LINES_PER_BANK
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         rise_i,
  input  logic [W-1:0]         fall_i,
  input  logic                 wr_i,
  input  logic [REG_SEL_W-1:0] reg_sel_i,
  input  logic [W-1:0]         wdata_i,
  output logic [W-1:0]         rsel_o,
  output logic [W-1:0]         fsel_o,
  output logic [W-1:0]         imask_o,
  output logic [W-1:0]         emask_o,
  output logic [W-1:0]         rpend_o,
  output logic [W-1:0]         fpend_o,
  output logic                 irq_o,
  output logic [W-1:0]         evt_o
);
  logic [W-1:0] det_r, det_f, clr_r, clr_f;

  assign det_r = rise_i & rsel_o;
  assign det_f = fall_i & fsel_o;
  assign clr_r = (wr_i && reg_sel_i == REG_RISE_PEND) ? wdata_i : '0;
  assign clr_f = (wr_i && reg_sel_i == REG_FALL_PEND) ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_o  <= '0;
      fsel_o  <= '0;
      imask_o <= '0;
      emask_o <= '0;
      rpend_o <= '0;
      fpend_o <= '0;
      irq_o   <= 1'b0;
      evt_o   <= '0;
    end else begin
      if (wr_i) begin
        case (reg_sel_i)
          REG_RISE_SEL: rsel_o  <= wdata_i;
          REG_FALL_SEL: fsel_o  <= wdata_i;
          REG_IRQ_MASK: imask_o <= wdata_i;
          REG_EVT_MASK: emask_o <= wdata_i;
          default: ;
        endcase
      end
      // detection wins over a same-cycle clear
      rpend_o <= (rpend_o & ~clr_r) | det_r;
      fpend_o <= (fpend_o & ~clr_f) | det_f;
      irq_o   <= |((rpend_o | fpend_o) & imask_o);
      evt_o   <= (det_r | det_f) & imask_o & emask_o;
    end
  end
endmodule

// File: rtl/edge_irq_hub.sv
module edge_irq_hub
  import edge_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = LINES_PER_BANK,
  localparam int NUM_LINES = NUM_BANKS * BANK_W,
  localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [BSEL_W-1:0]    bank_sel,
  input  logic [REG_SEL_W-1:0] reg_sel,
  input  logic                 wr_en,
  input  logic [BANK_W-1:0]    wdata,
  input  logic                 rd_en,
  output logic [BANK_W-1:0]    rdata,
  output logic [NUM_BANKS-1:0] bank_irq_o,
  output logic                 any_irq_o,
  output logic [NUM_LINES-1:0] evt_o
);
  logic [NUM_LINES-1:0] rise_all, fall_all;
  logic [NUM_LINES-1:0] rp_all, fp_all, im_all, em_all;
  logic [BANK_W-1:0] rsel_a [NUM_BANKS];
  logic [BANK_W-1:0] fsel_a [NUM_BANKS];
  logic [BANK_W-1:0] rd_word;

  line_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst(rst), .din(lines_i), .rise_o(rise_all), .fall_o(fall_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (bank_sel == BSEL_W'(b));
    edge_bank #(.W(BANK_W)) u_bank (
      .clk(clk), .rst(rst),
      .rise_i(rise_all[b*BANK_W +: BANK_W]),
      .fall_i(fall_all[b*BANK_W +: BANK_W]),
      .wr_i(bank_we), .reg_sel_i(reg_sel), .wdata_i(wdata),
      .rsel_o(rsel_a[b]), .fsel_o(fsel_a[b]),
      .imask_o(im_all[b*BANK_W +: BANK_W]),
      .emask_o(em_all[b*BANK_W +: BANK_W]),
      .rpend_o(rp_all[b*BANK_W +: BANK_W]),
      .fpend_o(fp_all[b*BANK_W +: BANK_W]),
      .irq_o(bank_irq_o[b]),
      .evt_o(evt_o[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BSEL_W'(b)) begin
        case (reg_sel)
          REG_RISE_SEL:  rd_word = rsel_a[b];
          REG_FALL_SEL:  rd_word = fsel_a[b];
          REG_IRQ_MASK:  rd_word = im_all[b*BANK_W +: BANK_W];
          REG_EVT_MASK:  rd_word = em_all[b*BANK_W +: BANK_W];
          REG_RISE_PEND: rd_word = rp_all[b*BANK_W +: BANK_W];
          REG_FALL_PEND: rd_word = fp_all[b*BANK_W +: BANK_W];
          default:       rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      any_irq_o <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_word;
      any_irq_o <= |((rp_all | fp_all) & im_all);
    end
  end
endmodule

// File: rtl/edge_irq_hub_chk.sv
module edge_irq_hub_chk #(
  parameter int NB = 3,
  parameter int W  = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [NB-1:0]   bank_irq_o,
  input logic            any_irq_o,
  input logic [NB*W-1:0] evt_o,
  input logic [NB*W-1:0] rp_all,
  input logic [NB*W-1:0] fp_all,
  input logic [NB*W-1:0] im_all,
  input logic [NB*W-1:0] em_all
);
  AST_RISE_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> (($past(rp_all) & ~rp_all) == '0)); // R4
  AST_FALL_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> (($past(fp_all) & ~fp_all) == '0)); // R4
  AST_EVT_GATED: assert property (@(posedge clk) disable iff (rst)
    (evt_o & ~($past(im_all) & $past(em_all))) == '0); // R6
  AST_ANY_IRQ_OR: assert property (@(posedge clk) disable iff (rst)
    any_irq_o == (|bank_irq_o)); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (rp_all == '0 && fp_all == '0 && bank_irq_o == '0 && evt_o == '0)); // R8

  for (genvar b = 0; b < NB; b++) begin : g_irq
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
      bank_irq_o[b] == $past(|((rp_all[b*W +: W] | fp_all[b*W +: W]) & im_all[b*W +: W]))); // R5
  end
endmodule

bind edge_irq_hub edge_irq_hub_chk #(.NB(NUM_BANKS), .W(BANK_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .bank_irq_o(bank_irq_o),
  .any_irq_o(any_irq_o), .evt_o(evt_o), .rp_all(rp_all), .fp_all(fp_all),
  .im_all(im_all), .em_all(em_all)
);

// File: tb/sim_edge_irq_hub.sv
`timescale 1ns/1ps
module sim_edge_irq_hub;
  localparam int NB = 3;
  localparam int W  = 32;
  localparam logic [2:0] RSEL = 3'd0, FSEL = 3'd1, IMSK = 3'd2,
                         EMSK = 3'd3, RPND = 3'd4, FPND = 3'd5;

  logic clk = 1'b0;
  logic rst;
  logic [NB*W-1:0] lines;
  logic [1:0] bank_sel;
  logic [2:0] reg_sel;
  logic wr_en, rd_en;
  logic [W-1:0] wdata, rdata;
  logic [NB-1:0] bank_irq;
  logic any_irq;
  logic [NB*W-1:0] evt;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  edge_irq_hub u0 (
    .clk(clk), .rst(rst), .lines_i(lines), .bank_sel(bank_sel), .reg_sel(reg_sel),
    .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
    .bank_irq_o(bank_irq), .any_irq_o(any_irq), .evt_o(evt)
  );

  // table: rise select, fall select, start level, end level, expected rise/fall pending
  localparam logic [31:0] TV_RS [6] = '{32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF, 32'h8000_0001};
  localparam logic [31:0] TV_FS [6] = '{32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_0000, 32'h8000_0001};
  localparam logic [31:0] TV_ST [6] = '{32'h0, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'h0, 32'hAAAA_AAAA, 32'h8000_0000};
  localparam logic [31:0] TV_EN [6] = '{32'h0000_00FF, 32'h0, 32'hF0F0_F0F0, 32'hFFFF_FFFF, 32'h5555_5555, 32'h0000_0001};
  localparam logic [31:0] TV_RP [6] = '{32'h0000_00FF, 32'h0, 32'hF0F0_F0F0, 32'h0, 32'h0000_5555, 32'h0000_0001};
  localparam logic [31:0] TV_FP [6] = '{32'h0, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'h0, 32'hAAAA_0000, 32'h8000_0000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] b, input logic [2:0] r, input logic [31:0] d);
    bank_sel = b; reg_sel = r; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] b, input logic [2:0] r, output logic [31:0] v);
    bank_sel = b; reg_sel = r; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; lines = '0; bank_sel = '0; reg_sel = '0;
    wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R8 reset state
    for (int r = 0; r < 6; r++) begin
      rd(2'd0, 3'(r), v);
      check("R8 reg zero", v, 32'h0);
    end
    check("R8 irq low", {29'h0, bank_irq}, 32'h0);
    check("R8 any low", {31'h0, any_irq}, 32'h0);
    check("R8 evt low", evt[31:0], 32'h0);

    // R2 R3 vector table walk
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, RSEL, 32'h0);
      wr(2'd0, FSEL, 32'h0);
      lines[31:0] = TV_ST[i];
      idle(5);
      wr(2'd0, RPND, 32'hFFFF_FFFF);
      wr(2'd0, FPND, 32'hFFFF_FFFF);
      wr(2'd0, RSEL, TV_RS[i]);
      wr(2'd0, FSEL, TV_FS[i]);
      lines[31:0] = TV_EN[i];
      idle(5);
      rd(2'd0, RPND, v);
      check("R2 rise pending", v, TV_RP[i]);
      rd(2'd0, FPND, v);
      check("R3 fall pending", v, TV_FP[i]);
    end

    // R9 readback of select register and out-of-range bank
    rd(2'd0, RSEL, v);
    check("R9 select readback", v, 32'h8000_0001);
    rd(2'd3, RSEL, v);
    check("R9 bank out of range", v, 32'h0);

    // R4 partial clear of both pending registers (bit0 rise, bit31 fall set)
    wr(2'd0, RPND, 32'h0000_0002);
    rd(2'd0, RPND, v);
    check("R4 rise kept", v, 32'h0000_0001);
    wr(2'd0, FPND, 32'h8000_0000);
    rd(2'd0, FPND, v);
    check("R4 fall cleared", v, 32'h0);
    wr(2'd0, RPND, 32'h0000_0001);
    rd(2'd0, RPND, v);
    check("R4 rise cleared", v, 32'h0);

    // R5 masking and level interrupt
    wr(2'd0, RSEL, 32'h0000_0008);
    wr(2'd0, FSEL, 32'h0);
    lines = '0;
    idle(5);
    wr(2'd0, RPND, 32'hFFFF_FFFF);
    wr(2'd0, FPND, 32'hFFFF_FFFF);
    lines[3] = 1'b1;
    idle(6);
    check("R5 masked no irq", {31'h0, bank_irq[0]}, 32'h0);
    rd(2'd0, RPND, v);
    check("R5 latched while masked", v, 32'h0000_0008);
    wr(2'd0, IMSK, 32'h0000_0008);
    idle(2);
    check("R5 irq high", {31'h0, bank_irq[0]}, 32'h1);
    check("R5 any high", {31'h0, any_irq}, 32'h1);
    idle(3);
    check("R5 level held", {31'h0, bank_irq[0]}, 32'h1);
    wr(2'd0, RPND, 32'h0000_0008);
    idle(2);
    check("R5 irq dropped", {31'h0, bank_irq[0]}, 32'h0);
    check("R5 any dropped", {31'h0, any_irq}, 32'h0);

    // R1 line 69 maps to bank 2 bit 5
    wr(2'd2, RSEL, 32'h0000_0020);
    lines[69] = 1'b1;
    idle(5);
    rd(2'd2, RPND, v);
    check("R1 bank2 bit5", v, 32'h0000_0020);
    rd(2'd1, RPND, v);
    check("R1 bank1 untouched", v, 32'h0);
    rd(2'd0, RPND, v);
    check("R1 bank0 untouched", v, 32'h0);

    // R6 R10 event pulse: bit4 fully enabled, bit5 irq-masked
    wr(2'd0, RSEL, 32'h0000_0030);
    wr(2'd0, IMSK, 32'h0000_0010);
    wr(2'd0, EMSK, 32'h0000_0030);
    lines[5:4] = 2'b11;
    idle(2);
    check("R10 no early pulse", {30'h0, evt[5:4]}, 32'h0);
    idle(1);
    check("R6 pulse only bit4", {30'h0, evt[5:4]}, 32'h1);
    idle(1);
    check("R6 pulse one cycle", {30'h0, evt[5:4]}, 32'h0);

    // R7 edge and clear in the same cycle
    wr(2'd0, RSEL, 32'h0000_0001);
    wr(2'd0, IMSK, 32'h0);
    lines[0] = 1'b1;
    idle(5);
    lines[0] = 1'b0;
    idle(5);
    rd(2'd0, RPND, v);
    check("R7 setup pending", v & 32'h1, 32'h1);
    lines[0] = 1'b1;
    idle(2);
    bank_sel = 2'd0; reg_sel = RPND; wdata = 32'h1; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd0, RPND, v);
    check("R7 edge wins", v & 32'h1, 32'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule